// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block supplies the address for a synchronous memory that runs short bursts. A burst starts when either of two independent address-status strobes is high at a rising clock edge. The whole input address is then captured. Its two lowest bits become the seed of a two-bit beat counter, and its upper bits are held as the burst's base.

Each later clock edge with the advance input high and no strobe moves the beat counter on by one. The counter wraps after four beats. The low two output bits are formed from the seed and the beat count. A static order-select input picks how: low gives linear order (seed plus count, modulo four), and high gives interleaved order (seed XOR count). The upper output bits come from the captured base and stay fixed until the next strobe.

The output address is a registered value. A load or an advance shows at the output right after the clock edge that samples it. On the board, the order-select pin is expected to have a pull-up, so that an unconnected pin reads high and selects interleaved order.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no strobe yet seen, the output address is all zeros.
- R2: A rising clock edge with either strobe high loads the input address. From that edge onward the output equals the whole input address sampled at that edge.
- R3: An edge with no strobe and with advance low leaves the output address unchanged.
- R4: With order-select low (linear), the low two output bits after k advances equal (seed + k) mod 4.
- R5: With order-select high (interleaved), the low two output bits after k advances equal seed XOR (k mod 4).
- R6: The fifth advance after a load wraps the low two bits back to the value after the first advance, and the fourth advance returns them to the seed.
- R7: When a strobe and advance are both high at the same edge, the load wins. The output equals the new input address with a beat count of zero.
- R8: The upper address bits (all bits above bit 1) stay equal to the captured base through advances and holds, even if the input address changes.
- R9: Both strobes high together act exactly like a single strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_p | input | 1 | First address-status strobe; starts a burst |
| strobe_c | input | 1 | Second address-status strobe; starts a burst |
| advance | input | 1 | Steps the beat counter when no strobe is high |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | Full address offered with a strobe |
| addr_out | output | ADDR_W | Current memory address |

## Verification
The assertions check four things on every cycle:
- a strobe loads the sampled address;
- without a strobe the upper bits hold;
- an edge with neither strobe nor advance keeps the output still;
- each advance moves the low bits by the step its order demands (plus one in linear order, or the change in seed XOR count in interleaved order).

Three things can be seen only in the bench's sweep:
- the full four-beat sequences for every seed in both orders;
- the wrap on the fifth beat;
- a strobe taking priority over a same-cycle advance, and both strobes together acting like one.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_p,
  input  logic              strobe_c,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] base_hi;
  logic [1:0]      seed;
  logic [1:0]      beat;
  logic [1:0]      low;
  logic            start;

  assign start = strobe_p | strobe_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi <= '0;
      seed    <= '0;
      beat    <= '0;
    end else if (start) begin
      base_hi <= addr_in[ADDR_W-1:2];
      seed    <= addr_in[1:0];
      beat    <= '0;
    end else if (advance) begin
      beat <= beat + 2'd1;
    end
  end

  assign low      = order_sel ? (seed ^ beat) : (seed + beat);
  assign addr_out = {base_hi, low};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe_p,
  input logic              strobe_c,
  input logic              advance,
  input logic              order_sel,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic [1:0]        beat
);
  logic any_strobe;
  assign any_strobe = strobe_p | strobe_c;

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |=> addr_out == $past(addr_in));

  a_r8_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !any_strobe |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_strobe && !advance) |=> (order_sel != $past(order_sel)) || (addr_out == $past(addr_out)));

  a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_strobe && advance && !order_sel) |=>
      order_sel || (addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1)));

  a_r5_interleave_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_strobe && advance && order_sel) |=>
      !order_sel || (addr_out[1:0] == ($past(addr_out[1:0]) ^ $past(beat) ^ 2'($past(beat) + 2'd1))));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_p(strobe_p), .strobe_c(strobe_c),
  .advance(advance), .order_sel(order_sel), .addr_in(addr_in),
  .addr_out(addr_out), .beat(beat)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int W = 19;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         strobe_p = 1'b0;
  logic         strobe_c = 1'b0;
  logic         advance = 1'b0;
  logic         order_sel = 1'b0;
  logic [W-1:0] addr_in = '0;
  logic [W-1:0] addr_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(W)) u_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .strobe_p(strobe_p), .strobe_c(strobe_c),
    .advance(advance), .order_sel(order_sel), .addr_in(addr_in),
    .addr_out(addr_out)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_low(input logic m, input logic [1:0] s, input int k);
    logic [1:0] kk;
    kk = 2'(k);
    return m ? (s ^ kk) : 2'(s + kk);
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-3:0] hi;
    tick();
    tick();
    check("R1 during reset", addr_out, '0);
    rst_n = 1'b1;
    tick();
    tick();
    check("R1 after release", addr_out, '0);

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int v = 0; v < 2; v++) begin
          order_sel = m[0];
          hi = 17'h1A5C3 ^ 17'(s * 4099 + v * 911 + m * 77);
          addr_in = {hi, 2'(s)};
          strobe_p = (v == 0);
          strobe_c = (v == 1);
          advance = (v == 1);  // R7: advance alongside strobe must be ignored
          tick();
          check(v == 1 ? "R7 strobe over advance" : "R2 load", addr_out, {hi, 2'(s)});
          strobe_p = 1'b0;
          strobe_c = 1'b0;
          advance = 1'b1;
          addr_in = ~addr_in;  // R8: upper bits must not follow input
          for (int k = 1; k <= 5; k++) begin
            tick();
            if (k >= 4)
              check("R6 wrap", addr_out, {hi, exp_low(m[0], 2'(s), k)});
            else
              check(m == 0 ? "R4 linear R8 upper" : "R5 interleave R8 upper",
                    addr_out, {hi, exp_low(m[0], 2'(s), k)});
          end
          advance = 1'b0;
          tick();
          tick();
          check("R3 hold", addr_out, {hi, exp_low(m[0], 2'(s), 5)});
        end
      end
    end

    order_sel = 1'b0;
    addr_in = 19'h5_3C9E;
    strobe_p = 1'b1;
    strobe_c = 1'b1;
    tick();
    check("R9 both strobes", addr_out, 19'h5_3C9E);
    strobe_p = 1'b0;
    strobe_c = 1'b0;
    advance = 1'b1;
    tick();
    check("R9 both strobes then step", addr_out, 19'h5_3C9F);
    advance = 1'b0;

    rst_n = 1'b0;
    #1;
    check("R1 async reset", addr_out, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule